// File: doc/BRIEF.md
# Programmable Segment Address Decoder

This block turns a 16-bit logical CPU address into three active-low chip selects: one for the external bus, one for the program ROM and one for the address-translation registers. The address space is split into 32-byte segments. Each segment owns one byte of a writable map table, so a board's memory map is changed by loading new table contents rather than by editing logic.

The selects are only driven while either clock phase E or Q is high. That window covers three quarters of every bus cycle and keeps early read/write transients away from the selects. The translation-register select is further limited to write cycles. A jumper input is passed to the ROM's top address line, so the board can boot from either 4 KB image held in an 8 KB device.

When reset is released, an internal sequencer writes the default map into the table, one entry per clock, through the same write port that an external loader uses. A ready flag rises once the whole table is written. From then on, external table writes are accepted and CPU decoding is live.

Top module: `seg_decoder`

## Requirements
- R1: Bits 15:5 of `cpu_addr` form an 11-bit index into a 2048-entry, 8-bit map table. Bits 4:0 have no effect on the selects.
- R2: Each select is active (low) only when its table bit is 0. Bit 0 drives `bus_sel_n`, bit 1 drives `rom_sel_n` and bit 2 drives `xlat_sel_n`. Bits 7:3 are ignored.
- R3: When `phase_e` and `phase_q` are both low, all three selects are high.
- R4: `xlat_sel_n` can be low only on a write (`cpu_rw` = 0). On such a write the ROM select is held high for that segment. A read of the same segment follows table bit 1 for the ROM.
- R5: After initialisation, the map sends 0000-EFFF and F780-F7FF to the bus and F000-F77F and F800-FFFF to the ROM. Writes to FFE0-FFFF assert the translation select.
- R6: After `rst_n` is released, `map_ready` stays low for exactly 2048 rising clock edges and then stays high. While it is low, all selects are high.
- R7: With `map_ready` high, `tbl_we` = 1 writes `tbl_wdata` to entry `tbl_waddr` on the rising clock edge. While `map_ready` is low, `tbl_we` has no effect.
- R8: `rom_a12` always equals `rom_half_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for table writes and initialisation |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | Logical CPU address |
| phase_e | input | 1 | Bus clock phase E |
| phase_q | input | 1 | Bus clock phase Q |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| rom_half_sel | input | 1 | Jumper choosing the ROM's 4 KB half |
| tbl_we | input | 1 | Table write enable |
| tbl_waddr | input | 11 | Table entry to write |
| tbl_wdata | input | 8 | Entry value (active-low select bits) |
| map_ready | output | 1 | Table initialised, decoding live |
| bus_sel_n | output | 1 | External bus select, active low |
| rom_sel_n | output | 1 | Program ROM select, active low |
| xlat_sel_n | output | 1 | Translation-register select, active low |
| rom_a12 | output | 1 | ROM upper address line |

## Verification
On every cycle, the assertions check four rules. Selects are off outside the E/Q window. Selects are off before the table is ready. The translation select appears only on writes and never together with the ROM select. The ready flag never falls once it has risen. Only the bench scenarios can show that the right entry is consulted: these cover the default map contents for every segment and both directions, the exact length of initialisation, and that loads are accepted after initialisation but dropped during it. They also cover that address bits 4:0 and table bits 7:3 do not matter.

// File: rtl/seg_dec_pkg.sv
// Shared constants and the default map function for the segment decoder.
// Assumes a 64 KB space split into 32-byte segments; select bits are active low.
package seg_dec_pkg;
    localparam int ADDR_W  = 16;
    localparam int SEG_W   = 5;
    localparam int IDX_W   = ADDR_W - SEG_W;
    localparam int ENT_W   = 8;
    localparam int BIT_BUS = 0;
    localparam int BIT_ROM = 1;
    localparam int BIT_XLT = 2;

    // Segment index boundaries of the default map
    localparam logic [IDX_W-1:0] IDX_ROM_LO  = IDX_W'(16'hF000 >> SEG_W);
    localparam logic [IDX_W-1:0] IDX_HOLE_LO = IDX_W'(16'hF780 >> SEG_W);
    localparam logic [IDX_W-1:0] IDX_HOLE_HI = IDX_W'(16'hF7FF >> SEG_W);
    localparam logic [IDX_W-1:0] IDX_XLT     = IDX_W'(16'hFFE0 >> SEG_W);

    // Default entry for a segment: all bits high except the selects it uses
    function automatic logic [ENT_W-1:0] default_entry(input logic [IDX_W-1:0] idx);
        logic [ENT_W-1:0] e;
        e = '1;
        if (idx < IDX_ROM_LO)
            e[BIT_BUS] = 1'b0;
        else if (idx >= IDX_HOLE_LO && idx <= IDX_HOLE_HI)
            e[BIT_BUS] = 1'b0;
        else
            e[BIT_ROM] = 1'b0;
        if (idx >= IDX_XLT)
            e[BIT_XLT] = 1'b0;
        return e;
    endfunction
endpackage

// File: rtl/seg_map_init.sv
// Walks every table entry once after reset, emitting default map writes.
// Assumes one write per clock; busy stays high until the last entry is written.
module seg_map_init
    import seg_dec_pkg::*;
#(
    parameter int P_IDX_W = IDX_W,
    parameter int P_ENT_W = ENT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               init_we,
    output logic [P_IDX_W-1:0] init_idx,
    output logic [P_ENT_W-1:0] init_data,
    output logic               busy
);
    localparam logic [P_IDX_W-1:0] LAST_IDX = '1;

    logic [P_IDX_W-1:0] cnt;

    // Step the entry counter and clear busy after the final entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b1;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST_IDX)
                busy <= 1'b0;
        end
    end

    // Present the current entry and its default value to the table
    always_comb begin
        init_we   = busy;
        init_idx  = cnt;
        init_data = P_ENT_W'(default_entry(IDX_W'(cnt)));
    end
endmodule

// File: rtl/seg_map_table.sv
// Map storage: one synchronous write port, one asynchronous read port.
// Assumes the write port is already arbitrated by the caller.
module seg_map_table #(
    parameter int P_IDX_W = 11,
    parameter int P_ENT_W = 8
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [P_IDX_W-1:0] wr_idx,
    input  logic [P_ENT_W-1:0] wr_data,
    input  logic [P_IDX_W-1:0] rd_idx,
    output logic [P_ENT_W-1:0] rd_data
);
    localparam int DEPTH = 1 << P_IDX_W;

    logic [P_ENT_W-1:0] mem [DEPTH];

    // Store an entry on the clock edge when enabled
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_idx] <= wr_data;
    end

    // Return the entry addressed by the CPU segment index
    always_comb rd_data = mem[rd_idx];
endmodule

// File: rtl/seg_sel_logic.sv
// Turns one table entry into the three active-low selects.
// Assumes cpu_rw is 1 for read; the write-only select overrides the ROM select.
module seg_sel_logic
    import seg_dec_pkg::*;
#(
    parameter int P_ENT_W = ENT_W
) (
    input  logic [P_ENT_W-1:0] entry,
    input  logic               phase_e,
    input  logic               phase_q,
    input  logic               cpu_rw,
    input  logic               ready,
    output logic               bus_sel_n,
    output logic               rom_sel_n,
    output logic               xlat_sel_n
);
    logic window;
    logic xlt_hit;

    // Qualify table bits with the bus window, direction and readiness
    always_comb begin
        window     = (phase_e | phase_q) & ready;
        xlt_hit    = ~entry[BIT_XLT] & ~cpu_rw;
        bus_sel_n  = ~(window & ~entry[BIT_BUS]);
        xlat_sel_n = ~(window & xlt_hit);
        rom_sel_n  = ~(window & ~entry[BIT_ROM] & ~xlt_hit);
    end
endmodule

// File: rtl/seg_decoder.sv
// Top of the programmable segment decoder: initialiser, map table and select logic.
// Assumes an external loader writes the table only after map_ready rises.
module seg_decoder
    import seg_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              phase_e,
    input  logic              phase_q,
    input  logic              cpu_rw,
    input  logic              rom_half_sel,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_waddr,
    input  logic [ENT_W-1:0]  tbl_wdata,
    output logic              map_ready,
    output logic              bus_sel_n,
    output logic              rom_sel_n,
    output logic              xlat_sel_n,
    output logic              rom_a12
);
    logic             init_we;
    logic             init_busy;
    logic [IDX_W-1:0] init_idx;
    logic [ENT_W-1:0] init_data;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [ENT_W-1:0] wr_data;
    logic [ENT_W-1:0] entry;

    seg_map_init #(.P_IDX_W(IDX_W), .P_ENT_W(ENT_W)) u_init (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_we   (init_we),
        .init_idx  (init_idx),
        .init_data (init_data),
        .busy      (init_busy)
    );

    // Give the initialiser the write port while it runs; drop external loads then
    always_comb begin
        if (init_busy) begin
            wr_en   = init_we;
            wr_idx  = init_idx;
            wr_data = init_data;
        end else begin
            wr_en   = tbl_we;
            wr_idx  = tbl_waddr;
            wr_data = tbl_wdata;
        end
    end

    seg_map_table #(.P_IDX_W(IDX_W), .P_ENT_W(ENT_W)) u_table (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (cpu_addr[ADDR_W-1:SEG_W]),
        .rd_data (entry)
    );

    seg_sel_logic #(.P_ENT_W(ENT_W)) u_sel (
        .entry      (entry),
        .phase_e    (phase_e),
        .phase_q    (phase_q),
        .cpu_rw     (cpu_rw),
        .ready      (~init_busy),
        .bus_sel_n  (bus_sel_n),
        .rom_sel_n  (rom_sel_n),
        .xlat_sel_n (xlat_sel_n)
    );

    // Ready flag and ROM half jumper pass-through
    always_comb begin
        map_ready = ~init_busy;
        rom_a12   = rom_half_sel;
    end
endmodule

// File: rtl/seg_decoder_chk.sv
// Cycle-by-cycle rules for the segment decoder, bound onto every instance.
module seg_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic phase_e,
    input logic phase_q,
    input logic cpu_rw,
    input logic map_ready,
    input logic bus_sel_n,
    input logic rom_sel_n,
    input logic xlat_sel_n
);
    p_window_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_e && !phase_q) |-> (bus_sel_n && rom_sel_n && xlat_sel_n));

    p_not_ready_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !map_ready |-> (bus_sel_n && rom_sel_n && xlat_sel_n));

    p_ready_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        map_ready |=> map_ready);

    p_xlat_write_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !xlat_sel_n |-> !cpu_rw);

    p_xlat_excl_rom_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !xlat_sel_n |-> rom_sel_n);
endmodule

bind seg_decoder seg_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_e    (phase_e),
    .phase_q    (phase_q),
    .cpu_rw     (cpu_rw),
    .map_ready  (map_ready),
    .bus_sel_n  (bus_sel_n),
    .rom_sel_n  (rom_sel_n),
    .xlat_sel_n (xlat_sel_n)
);

// File: tb/seg_decoder_test.sv
// Bench for seg_decoder: directed corners plus seeded random stimulus.
module seg_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        phase_e = 1'b0;
    logic        phase_q = 1'b0;
    logic        cpu_rw = 1'b1;
    logic        rom_half_sel = 1'b0;
    logic        tbl_we = 1'b0;
    logic [10:0] tbl_waddr = '0;
    logic [7:0]  tbl_wdata = '0;
    logic        map_ready, bus_sel_n, rom_sel_n, xlat_sel_n, rom_a12;

    int n_tests = 0;
    int n_fail = 0;
    logic [7:0] model [2048];

    seg_decoder uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .phase_e(phase_e),
        .phase_q(phase_q), .cpu_rw(cpu_rw), .rom_half_sel(rom_half_sel),
        .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
        .map_ready(map_ready), .bus_sel_n(bus_sel_n), .rom_sel_n(rom_sel_n),
        .xlat_sel_n(xlat_sel_n), .rom_a12(rom_a12)
    );

    always #10 clk = ~clk;

    // Default map from the requirements (R5), active-low bits {xlat, rom, bus}
    function automatic logic [7:0] ref_default(input int idx);
        int a;
        logic [7:0] e;
        a = idx * 32;
        e = 8'hFF;
        if (a < 16'hF000 || (a >= 16'hF780 && a <= 16'hF7FF)) e[0] = 1'b0;
        else e[1] = 1'b0;
        if (a >= 16'hFFE0) e[2] = 1'b0;
        return e;
    endfunction

    // Expected selects {bus, rom, xlat} from an entry (R2, R3, R4)
    function automatic logic [2:0] ref_sel(input logic [7:0] e, input logic rw,
                                           input logic win);
        logic x;
        x = win & ~e[2] & ~rw;
        return {~(win & ~e[0]), ~(win & ~e[1] & ~x), ~x};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive a CPU access at the falling edge and compare selects shortly after
    task automatic probe(input string tag, input logic [15:0] a, input logic rw,
                         input logic e, input logic q);
        @(negedge clk);
        cpu_addr = a; cpu_rw = rw; phase_e = e; phase_q = q;
        #2;
        check(tag, {29'd0, bus_sel_n, rom_sel_n, xlat_sel_n},
              {29'd0, ref_sel(model[a[15:5]], rw, e | q)});
    endtask

    task automatic load(input logic [10:0] idx, input logic [7:0] d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_waddr = idx; tbl_wdata = d;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2048; i++) model[i] = ref_default(i);

        repeat (3) @(posedge clk);
        #2;
        check("R6 reset map_ready", {31'd0, map_ready}, 32'd0);
        check("R6 reset selects", {29'd0, bus_sel_n, rom_sel_n, xlat_sel_n}, 32'd7);

        // Release reset and try an external load that must be dropped (R7)
        @(negedge clk);
        rst_n = 1'b1;
        tbl_we = 1'b1; tbl_waddr = 11'd0; tbl_wdata = 8'h00;
        cpu_addr = 16'h0000; cpu_rw = 1'b0; phase_e = 1'b1;
        cyc = 0;
        while (cyc < 3000) begin
            @(posedge clk);
            cyc++;
            #2;
            if (cyc == 5) begin
                tbl_we = 1'b0;
                check("R6 selects idle during init",
                      {29'd0, bus_sel_n, rom_sel_n, xlat_sel_n}, 32'd7);
            end
            if (map_ready) break;
        end
        check("R6 init length", cyc, 32'd2048);
        phase_e = 1'b0;

        probe("R7 load ignored during init", 16'h0000, 1'b0, 1'b1, 1'b0);

        // Full sweep of default map, both directions, random low bits (R1, R5)
        for (int i = 0; i < 2048; i++) begin
            for (int rw = 0; rw < 2; rw++) begin
                logic [1:0] ph;
                ph = 2'($urandom_range(1, 3));
                probe("R5 R1 default sweep", {i[10:0], 5'($urandom)}, rw[0], ph[1], ph[0]);
            end
        end

        // Directed corners at map boundaries
        probe("R5 EFFF bus", 16'hEFFF, 1'b1, 1'b1, 1'b0);
        probe("R5 F000 rom", 16'hF000, 1'b1, 1'b0, 1'b1);
        probe("R5 F77F rom", 16'hF77F, 1'b1, 1'b1, 1'b1);
        probe("R5 F780 bus", 16'hF780, 1'b0, 1'b1, 1'b0);
        probe("R5 F800 rom", 16'hF800, 1'b1, 1'b1, 1'b0);
        probe("R4 FFE0 read rom", 16'hFFE0, 1'b1, 1'b1, 1'b0);
        probe("R4 FFFF write xlat", 16'hFFFF, 1'b0, 1'b0, 1'b1);
        probe("R4 FFDF write rom", 16'hFFDF, 1'b0, 1'b1, 1'b0);

        // Outside the E/Q window nothing is selected (R3)
        for (int k = 0; k < 200; k++)
            probe("R3 window off", 16'($urandom), 1'($urandom), 1'b0, 1'b0);

        // Random table loads, then decode the loaded segments (R7, R2)
        for (int k = 0; k < 60; k++) begin
            logic [10:0] idx;
            logic [7:0] d;
            idx = 11'($urandom);
            d = 8'($urandom);
            load(idx, d);
            model[idx] = d;
            probe("R7 R2 loaded read", {idx, 5'($urandom)}, 1'b1, 1'b1, 1'b0);
            probe("R7 R2 loaded write", {idx, 5'($urandom)}, 1'b0, 1'b0, 1'b1);
        end

        // Upper bits of an entry must not matter (R2)
        load(11'd100, 8'h07);
        model[100] = 8'h07;
        probe("R2 upper bits clear, none selected", {11'd100, 5'd3}, 1'b0, 1'b1, 1'b0);
        load(11'd101, 8'hF8);
        model[101] = 8'hF8;
        probe("R2 upper bits set, all low bits active", {11'd101, 5'd9}, 1'b0, 1'b1, 1'b0);

        // Jumper pass-through (R8)
        for (int j = 0; j < 2; j++) begin
            @(negedge clk);
            rom_half_sel = j[0];
            #2;
            check("R8 rom_a12", {31'd0, rom_a12}, {31'd0, j[0]});
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule